// File: doc/BRIEF.md
# Multiphase Clock Generator

This block turns one reference clock into four square-wave clock signals that are spaced evenly in phase. A power-of-two prescaler comes first. A slot sequencer follows it and forms two-phase, three-phase or four-phase output sets. The reference clock runs at twice the master rate. Each prescaled period therefore spans two prescaler ticks ("slots"), which allows 50% duty outputs at the prescaled rate. In the timing below, d is the value of `div_sel`.

The typical use is clocking interleaved switching stages. Software or straps drive the two select inputs. The block samples them only at the boundary between output cycles, so a setting change never produces a cut or stretched pulse on output 1. All phase positions restart together from slot 0.

Top module: `multiphase_clkgen`

## Requirements
- R1: One slot lasts 2^d reference cycles, with d = `div_sel` (00 to 11, so the master rate is divided by 1, 2, 4 or 8). One output cycle lasts 2·2^d reference cycles in two-phase mode, 6·2^d in three-phase mode and 8·2^d in four-phase mode.
- R2: `phase_sel` = 00 selects two-phase mode. `phase_out[0]` is high in the first half of the cycle and `phase_out[1]` in the second half. `phase_out[2]` equals `phase_out[0]` and `phase_out[3]` equals `phase_out[1]`.
- R3: `phase_sel` = 01 selects three-phase mode. `phase_out[0]`, `phase_out[1]` and `phase_out[2]` are each high for one third of the cycle, in that order, with exactly one of them high at any time. `phase_out[3]` stays low.
- R4: `phase_sel` = 10 selects four-phase mode. Every output has 50% duty. `phase_out[k+1]` lags `phase_out[k]` by a quarter cycle (2·2^d reference cycles), so the pairs 0/2 and 1/3 are never high together.
- R5: `phase_sel` = 11 behaves exactly like 00. Switching between 00 and 11 causes no visible change.
- R6: `div_sel` and `phase_sel` are sampled only at the reference edge that ends an output cycle, and at the first edge after reset. A change made in the middle of a cycle leaves the rest of that cycle unchanged, and the new setting starts from slot 0.
- R7: In the first cycle after reset, or after a change of mode, `phase_out[3]` does not carry the four-phase pulse that would wrap across the cycle start: it stays low for the first quarter. A change of `div_sel` alone keeps that pulse continuous.
- R8: While `rst_n` is low all outputs are low, asynchronously. After release, `phase_out[0]` rises on the second reference edge, and no output is high before that first rise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock, twice the master rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| div_sel | input | 2 | Prescaler select, divide by 2^div_sel |
| phase_sel | input | 2 | Phase mode: 00 two, 01 three, 10 four, 11 as 00 |
| phase_out | output | 4 | Phase outputs, bit 0 is output 1 |

## Verification
The main function is driven with every phase code at several prescaler settings. The slowest four-phase setting shows whether slot length scales with `div_sel`, while the fastest two-phase setting shows the one-slot half period. Code 11 runs against the same expectation as 00, which separates correct aliasing from a distinct fourth pattern. Mid-cycle changes of mode alone and of prescaler alone separate boundary sampling from immediate sampling, and separate suppression of the first wrapped output-4 pulse from continuing it.

// File: rtl/mpg_pkg.sv
package mpg_pkg;

  localparam int SLOT_W  = 3;
  localparam int NUM_OUT = 4;

  typedef enum logic [1:0] {
    MODE_TWO   = 2'b00,
    MODE_THREE = 2'b01,
    MODE_FOUR  = 2'b10,
    MODE_RSVD  = 2'b11
  } mode_e;

  // Reserved code folds onto two-phase operation.
  function automatic mode_e mode_resolve(input logic [1:0] code);
    return (code == 2'b11) ? MODE_TWO : mode_e'(code);
  endfunction

  // Index of the final slot of one output cycle.
  function automatic logic [SLOT_W-1:0] mode_last_slot(input mode_e m);
    case (m)
      MODE_THREE: return SLOT_W'(5);
      MODE_FOUR:  return SLOT_W'(7);
      default:    return SLOT_W'(1);
    endcase
  endfunction

  // Output levels for one slot; bit 0 is output 1.
  function automatic logic [NUM_OUT-1:0] slot_levels(input mode_e m,
                                                     input logic [SLOT_W-1:0] s,
                                                     input logic first);
    logic [NUM_OUT-1:0] v;
    v = '0;
    case (m)
      MODE_THREE: begin
        v[0] = (s < SLOT_W'(2));
        v[1] = (s == SLOT_W'(2)) || (s == SLOT_W'(3));
        v[2] = (s >= SLOT_W'(4));
      end
      MODE_FOUR: begin
        v[0] = (s < SLOT_W'(4));
        v[1] = (s >= SLOT_W'(2)) && (s < SLOT_W'(6));
        v[2] = (s >= SLOT_W'(4));
        v[3] = (s >= SLOT_W'(6)) || ((s < SLOT_W'(2)) && !first);
      end
      default: begin
        v[0] = (s == SLOT_W'(0));
        v[1] = (s == SLOT_W'(1));
        v[2] = v[0];
        v[3] = v[1];
      end
    endcase
    return v;
  endfunction

endpackage

// File: rtl/mpg_prescaler.sv
module mpg_prescaler #(
  parameter int SEL_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [SEL_W-1:0] sel,
  output logic             tick
);
  localparam int CNT_W = (1 << SEL_W) - 1;

  logic [CNT_W-1:0] cnt;
  logic [CNT_W:0]   span;
  logic [CNT_W-1:0] limit;

  assign span  = (CNT_W+1)'(1) << sel;
  assign limit = CNT_W'(span - (CNT_W+1)'(1));
  assign tick  = run && (cnt == limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt <= '0;
    else if (!run || tick) cnt <= '0;
    else                   cnt <= cnt + CNT_W'(1);
  end
endmodule

// File: rtl/mpg_sequencer.sv
module mpg_sequencer
  import mpg_pkg::*;
#(
  parameter int SEL_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic [SEL_W-1:0]  div_sel_i,
  input  logic [1:0]        phase_sel_i,
  output logic              run,
  output logic [SEL_W-1:0]  act_sel,
  output mode_e             act_mode,
  output logic [SLOT_W-1:0] slot,
  output logic              first,
  output logic              cycle_end
);
  mode_e next_mode;

  assign next_mode = mode_resolve(phase_sel_i);
  assign cycle_end = run && tick && (slot == mode_last_slot(act_mode));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run      <= 1'b0;
      act_sel  <= '0;
      act_mode <= MODE_TWO;
      slot     <= '0;
      first    <= 1'b1;
    end else if (!run) begin
      run      <= 1'b1;
      act_sel  <= div_sel_i;
      act_mode <= next_mode;
      slot     <= '0;
      first    <= 1'b1;
    end else if (cycle_end) begin
      act_sel  <= div_sel_i;
      act_mode <= next_mode;
      slot     <= '0;
      first    <= (next_mode != act_mode);
    end else if (tick) begin
      slot     <= slot + SLOT_W'(1);
    end
  end
endmodule

// File: rtl/mpg_pattern.sv
module mpg_pattern
  import mpg_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               run,
  input  mode_e              mode,
  input  logic [SLOT_W-1:0]  slot,
  input  logic               first,
  output logic [NUM_OUT-1:0] phase_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   phase_o <= '0;
    else if (run) phase_o <= slot_levels(mode, slot, first);
    else          phase_o <= '0;
  end
endmodule

// File: rtl/multiphase_clkgen.sv
module multiphase_clkgen
  import mpg_pkg::*;
#(
  parameter int SEL_W = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [SEL_W-1:0]   div_sel,
  input  logic [1:0]         phase_sel,
  output logic [NUM_OUT-1:0] phase_out
);
  logic              run;
  logic              tick;
  logic              cycle_end;
  logic              first;
  logic [SEL_W-1:0]  act_sel;
  mode_e             act_mode;
  logic [SLOT_W-1:0] slot;

  mpg_prescaler #(.SEL_W(SEL_W)) u_prescaler (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (run),
    .sel   (act_sel),
    .tick  (tick)
  );

  mpg_sequencer #(.SEL_W(SEL_W)) u_sequencer (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick        (tick),
    .div_sel_i   (div_sel),
    .phase_sel_i (phase_sel),
    .run         (run),
    .act_sel     (act_sel),
    .act_mode    (act_mode),
    .slot        (slot),
    .first       (first),
    .cycle_end   (cycle_end)
  );

  mpg_pattern u_pattern (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (run),
    .mode    (act_mode),
    .slot    (slot),
    .first   (first),
    .phase_o (phase_out)
  );
endmodule

// File: rtl/multiphase_clkgen_chk.sv
module multiphase_clkgen_chk
  import mpg_pkg::*;
#(
  parameter int SEL_W = 2
) (
  input logic               clk,
  input logic               rst_n,
  input logic [NUM_OUT-1:0] phase_out,
  input logic               run,
  input logic               tick,
  input logic               cycle_end,
  input logic [SEL_W-1:0]   act_sel,
  input mode_e              act_mode
);
  localparam int GAP_W = 1 << SEL_W;

  logic [GAP_W-1:0] gap;
  logic [GAP_W:0]   gap_span;
  logic             seen_o1;

  assign gap_span = (GAP_W+1)'(1) << act_sel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            gap <= '0;
    else if (!run || tick) gap <= '0;
    else                   gap <= gap + GAP_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            seen_o1 <= 1'b0;
    else if (phase_out[0]) seen_o1 <= 1'b1;
  end

  AST_TICK_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    (run && tick) |-> (gap == GAP_W'(gap_span - (GAP_W+1)'(1)))); // R1

  AST_TWO_PAIRS: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(run) && $past(act_mode) == MODE_TWO) |->
      (phase_out[2] == phase_out[0] && phase_out[3] == phase_out[1] &&
       phase_out[0] != phase_out[1])); // R2

  AST_THREE_ROTATE: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(run) && $past(act_mode) == MODE_THREE) |->
      ($countones(phase_out[2:0]) == 1 && !phase_out[3])); // R3

  AST_FOUR_ANTIPHASE: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(run) && $past(act_mode) == MODE_FOUR) |->
      (!(phase_out[0] && phase_out[2]) && !(phase_out[1] && phase_out[3]) &&
       phase_out != '0)); // R4

  AST_NO_RSVD_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (act_mode != MODE_RSVD)); // R5

  AST_CFG_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !cycle_end) |=> ($stable(act_mode) && $stable(act_sel))); // R6

  AST_QUIET_BEFORE_O1: assert property (@(posedge clk) disable iff (!rst_n)
    (!seen_o1 && !phase_out[0]) |-> (phase_out == '0)); // R8

  AST_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> (phase_out == '0)); // R8
endmodule

bind multiphase_clkgen multiphase_clkgen_chk #(.SEL_W(SEL_W)) i_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .phase_out (phase_out),
  .run       (run),
  .tick      (tick),
  .cycle_end (cycle_end),
  .act_sel   (act_sel),
  .act_mode  (act_mode)
);

// File: tb/test_multiphase_clkgen.sv
`timescale 1ns/1ps
module test_multiphase_clkgen;

  typedef struct packed {
    logic [1:0] dsel;
    logic [1:0] psel;
    logic [7:0] period;
  } vec_t;

  // Prescaler code, phase code, expected output period in reference cycles.
  localparam int NVEC = 10;
  localparam vec_t VECS [NVEC] = '{
    '{2'd0, 2'b00, 8'd2},
    '{2'd3, 2'b00, 8'd16},
    '{2'd0, 2'b01, 8'd6},
    '{2'd1, 2'b01, 8'd12},
    '{2'd2, 2'b01, 8'd24},
    '{2'd0, 2'b10, 8'd8},
    '{2'd1, 2'b10, 8'd16},
    '{2'd2, 2'b10, 8'd32},
    '{2'd3, 2'b10, 8'd64},
    '{2'd0, 2'b11, 8'd2}
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] div_sel = 2'd0;
  logic [1:0] phase_sel = 2'd0;
  logic [3:0] phase_out;
  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  multiphase_clkgen i_multiphase_clkgen (
    .clk       (clk),
    .rst_n     (rst_n),
    .div_sel   (div_sel),
    .phase_sel (phase_sel),
    .phase_out (phase_out)
  );

  // Expected levels from position p within a cycle of the given period.
  function automatic logic [3:0] model(input logic [1:0] code, input int period,
                                       input int p, input bit first);
    logic [3:0] o;
    int seg;
    o = 4'b0000;
    if (code == 2'b01) begin
      seg = (p * 3) / period;
      o[seg] = 1'b1;
    end else if (code == 2'b10) begin
      seg = (p * 4) / period;
      o[0] = (seg < 2);
      o[1] = (seg == 1) || (seg == 2);
      o[2] = (seg >= 2);
      o[3] = (seg == 3) || (seg == 0 && !first);
    end else begin
      o[0] = (p < period / 2);
      o[1] = !o[0];
      o[2] = o[0];
      o[3] = o[1];
    end
    return o;
  endfunction

  function automatic string mode_tag(input logic [1:0] code);
    case (code)
      2'b00:   return "R1 R2";
      2'b01:   return "R1 R3";
      2'b10:   return "R1 R4 R7";
      default: return "R1 R5";
    endcase
  endfunction

  task automatic check(input string req, input logic [3:0] exp);
    checks++;
    if (phase_out !== exp) begin
      fails++;
      $display("FAIL %s: phase_out=%b expected %b at %0t", req, phase_out, exp, $time);
    end
  endtask

  task automatic step(input string req, input logic [1:0] code, input int period,
                      input int n_rel, input bit fresh);
    @(negedge clk);
    check(req, model(code, period, n_rel % period, fresh && (n_rel < period)));
  endtask

  task automatic start(input logic [1:0] d, input logic [1:0] m);
    rst_n     = 1'b0;
    div_sel   = d;
    phase_sel = m;
    repeat (2) @(negedge clk);
    check("R8 held in reset", 4'b0000);
    rst_n = 1'b1;
    @(negedge clk);
    check("R8 low after first edge", 4'b0000);
  endtask

  initial begin
    // Table walk: each setting for three whole output cycles.
    for (int v = 0; v < NVEC; v++) begin
      start(VECS[v].dsel, VECS[v].psel);
      for (int n = 0; n < 3 * int'(VECS[v].period); n++)
        step(mode_tag(VECS[v].psel), VECS[v].psel, int'(VECS[v].period), n, 1'b1);
    end

    // R6: mode change mid-cycle waits for the boundary.
    start(2'd0, 2'b10);
    for (int n = 0; n < 4; n++) step("R6", 2'b10, 8, n, 1'b1);
    phase_sel = 2'b01;
    for (int n = 4; n < 8; n++) step("R6", 2'b10, 8, n, 1'b1);
    for (int n = 8; n < 20; n++) step("R6", 2'b01, 6, n - 8, 1'b1);

    // R7: entering four-phase suppresses the wrapped output-4 pulse.
    start(2'd1, 2'b00);
    step("R7", 2'b00, 4, 0, 1'b1);
    phase_sel = 2'b10;
    for (int n = 1; n < 4; n++) step("R7", 2'b00, 4, n, 1'b1);
    for (int n = 4; n < 36; n++) step("R7", 2'b10, 16, n - 4, 1'b1);

    // R7 and R6: a prescaler-only change keeps output 4 continuous.
    start(2'd0, 2'b10);
    for (int n = 0; n < 3; n++) step("R7", 2'b10, 8, n, 1'b1);
    div_sel = 2'd1;
    for (int n = 3; n < 8; n++) step("R6", 2'b10, 8, n, 1'b1);
    for (int n = 8; n < 40; n++) step("R7", 2'b10, 16, n - 8, 1'b0);

    // R5: switching between 00 and 11 has no effect on the outputs.
    start(2'd2, 2'b00);
    for (int n = 0; n < 3; n++) step("R5", 2'b00, 8, n, 1'b1);
    phase_sel = 2'b11;
    for (int n = 3; n < 40; n++) step("R5", 2'b00, 8, n, 1'b1);

    // R8: asynchronous reset in the middle of a run.
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R8 async clear", 4'b0000);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #400000;
    checks++;
    fails++;
    $display("FAIL watchdog: run did not complete, actual timeout expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule